// File: doc/BRIEF.md
# Three-Wire Serial Timekeeper Bus Master

This block is the host side of a three-wire link to a serial timekeeping chip. It drives a chip-enable line and a serial clock, and it drives or listens on one data line. A host hands it a request: a command byte plus a byte count. A count of one gives a single-byte access. A larger count gives a burst, in which chip-enable stays high while successive bytes are clocked. For writes, the host streams the data bytes through a valid/ready handshake. For reads, each assembled byte comes back with a one-cycle strobe.

The serial clock is derived from the system clock. A run-time divider sets the length of each serial clock phase. Every bit gets a low phase and then a high phase. Outgoing bits change only while the serial clock is low, so the peripheral captures them on the rising edge. Bits travel least significant first. On a read, the master lets go of the data line as soon as the eighth command clock rises. It samples each returned bit at the end of the following low phase, just before the next rising edge.

An abort input lowers chip-enable at once and ends the transfer at any point. After every frame, chip-enable stays low for at least one full serial clock period before the next request is taken. The data line is split into output, output-enable and input pins, which the pad ring joins.

Top module: `rtc3w_master`

## Requirements
- R1: While idle, chip-enable, serial clock and data output-enable are all low, busy is low and req_ready is high.
- R2: Chip-enable rises only while the serial clock is low, stays high for the whole frame, and the serial clock is high only while chip-enable is high.
- R3: Each serial clock high phase lasts exactly half_div+1 system clocks, and no low phase is shorter than that.
- R4: The first eight rising edges of a frame carry the command byte, least significant bit first, with the data line driven.
- R5: On a write (command bit 0 = 0), the data bytes follow the command in handshake order, each least significant bit first.
- R6: On a read (command bit 0 = 1), output-enable falls together with the eighth command rising edge and stays low for the rest of the frame.
- R7: On a read, the bits present on sio_i just before rising edges 9, 10, and so on are assembled least significant bit first. Every 8 bits give one rd_valid pulse, one cycle long, carrying that byte.
- R8: A frame has exactly 8 + 8·N rising edges, where N is req_len, and a req_len of 0 counts as 1.
- R9: If the next write byte has not arrived when a byte boundary is reached, the serial clock is held low with chip-enable high until the byte is supplied.
- R10: An abort during a frame drops chip-enable and output-enable on the next clock edge, and no further read byte is strobed for that frame.
- R11: Between the fall of chip-enable and its next rise there are at least 2·(half_div+1) system clocks. Busy stays high until that gap has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div | input | DIV_W | Serial clock phase length minus one, in system clocks |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when valid and ready are both high |
| req_cmd | input | 8 | Command byte; bit 0 chooses read (1) or write (0) |
| req_len | input | CNT_W | Data byte count (0 is taken as 1) |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte slot free |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle strobe for an assembled read byte |
| rd_data | output | 8 | Read byte |
| abort | input | 1 | Ends the current frame at once |
| busy | output | 1 | A frame or its trailing gap is in progress |
| ce | output | 1 | Chip-enable to the peripheral |
| sclk | output | 1 | Serial clock to the peripheral |
| sio_o | output | 1 | Data line output value |
| sio_oe | output | 1 | Data line output enable |
| sio_i | input | 1 | Data line input value |

## Verification
The bench holds a behavioural model of the peripheral. The model records what it sees on each rising edge and drives read bits after each falling edge, starting with the falling edge of the eighth command pulse. A master that sampled one edge too early would return every read byte shifted by one bit. One that kept driving after the command would be caught by the model's output-enable watch.

The bench also goes after these cases:
- A write whose second byte arrives very late. A master that failed to stall would clock out a stale byte.
- A zero byte count. A master that mishandled it would run zero or many data bytes.
- A divider of zero, where each phase is a single cycle.
- An abort in the middle of a read burst. A master that handled it wrongly would keep strobing bytes or leave chip-enable high.

Phase lengths, the inter-frame gap and the chip-enable rising edge are timed cycle by cycle.

// File: rtl/rtc3w_pkg.sv
package rtc3w_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BIT_IDX_W = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_TAIL,
    ST_GAP
  } rtc3w_state_e;
endpackage

// File: rtl/rtc3w_rstsync.sv
module rtc3w_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/rtc3w_clkdiv.sv
module rtc3w_clkdiv #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [DIV_W-1:0] lim,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == lim);
    cnt_d = cnt_q;
    if (clr || !run)  cnt_d = '0;
    else if (tick)    cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $stable(lim)) |-> (cnt_q <= lim));
endmodule

// File: rtl/rtc3w_wrbuf.sv
module rtc3w_wrbuf #(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [CNT_W-1:0] arm_cnt,
  input  logic             flush,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  output logic             in_ready,
  input  logic             take,
  output logic             full,
  output logic [DW-1:0]    data
);
  logic             full_q, full_d;
  logic [DW-1:0]    data_q, data_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             accept;

  assign in_ready = !full_q && (left_q != '0);
  assign accept   = in_valid && in_ready;

  always_comb begin
    full_d = full_q;
    data_d = data_q;
    left_d = left_q;
    if (flush) begin
      full_d = 1'b0;
      left_d = '0;
    end else if (arm) begin
      full_d = 1'b0;
      left_d = arm_cnt;
    end else if (accept) begin
      full_d = 1'b1;
      data_d = in_data;
      left_d = left_q - 1'b1;
    end else if (take) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
      left_q <= '0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
      left_q <= left_d;
    end
  end

  assign full = full_q;
  assign data = data_q;

  // R5
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !take && !flush && !arm) |=> (full_q && $stable(data_q)));
endmodule

// File: rtl/rtc3w_master.sv
module rtc3w_master
  import rtc3w_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [7:0]       req_cmd,
  input  logic [CNT_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  input  logic             abort,
  output logic             busy,
  output logic             ce,
  output logic             sclk,
  output logic             sio_o,
  output logic             sio_oe,
  input  logic             sio_i
);
  localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0]     ONE_BYTE = CNT_W'(1);

  logic rst_sn;
  rtc3w_rstsync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  rtc3w_state_e         state_q, state_d;
  logic                 ce_q, ce_d, sclk_q, sclk_d, oe_q, oe_d;
  logic [BYTE_W-1:0]    tx_q, tx_d, rx_q, rx_d, rdd_q, rdd_d;
  logic [BIT_IDX_W-1:0] bit_q, bit_d;
  logic                 cmd_ph_q, cmd_ph_d, rnw_q, rnw_d;
  logic                 wait_q, wait_d, gap_q, gap_d, rdv_q, rdv_d;
  logic [CNT_W-1:0]     left_q, left_d;

  logic             accept, abort_hit, tick, run, take, flush, arm;
  logic             buf_full;
  logic [7:0]       buf_data;
  logic [CNT_W-1:0] len_eff;
  logic [7:0]       rx_next;

  assign len_eff   = (req_len == '0) ? ONE_BYTE : req_len;
  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign abort_hit = abort && ((state_q == ST_LOW) || (state_q == ST_HIGH) ||
                               (state_q == ST_TAIL));
  assign run       = (state_q != ST_IDLE) && !wait_q;
  assign arm       = accept;
  assign rx_next   = {sio_i, rx_q[BYTE_W-1:1]};

  rtc3w_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_sn), .run(run), .clr(accept || abort_hit),
    .lim(half_div), .tick(tick)
  );

  rtc3w_wrbuf #(.CNT_W(CNT_W), .DW(BYTE_W)) u_wbuf (
    .clk(clk), .rst_n(rst_sn), .arm(arm),
    .arm_cnt(req_cmd[0] ? '0 : len_eff), .flush(flush),
    .in_valid(wr_valid), .in_data(wr_data), .in_ready(wr_ready),
    .take(take), .full(buf_full), .data(buf_data)
  );

  always_comb begin
    state_d  = state_q;
    ce_d     = ce_q;
    sclk_d   = sclk_q;
    oe_d     = oe_q;
    tx_d     = tx_q;
    rx_d     = rx_q;
    rdd_d    = rdd_q;
    bit_d    = bit_q;
    cmd_ph_d = cmd_ph_q;
    rnw_d    = rnw_q;
    wait_d   = wait_q;
    gap_d    = gap_q;
    left_d   = left_q;
    rdv_d    = 1'b0;
    take     = 1'b0;
    flush    = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d  = ST_LOW;
          ce_d     = 1'b1;
          sclk_d   = 1'b0;
          oe_d     = 1'b1;
          tx_d     = req_cmd;
          bit_d    = '0;
          cmd_ph_d = 1'b1;
          rnw_d    = req_cmd[0];
          left_d   = len_eff;
          wait_d   = 1'b0;
        end
      end
      ST_LOW: begin
        if (wait_q) begin
          if (buf_full) begin
            tx_d   = buf_data;
            take   = 1'b1;
            wait_d = 1'b0;
          end
        end else if (tick) begin
          state_d = ST_HIGH;
          sclk_d  = 1'b1;
          if (cmd_ph_q && rnw_q && (bit_q == LAST_BIT)) oe_d = 1'b0;
          if (!cmd_ph_q && rnw_q) begin
            rx_d = rx_next;
            if (bit_q == LAST_BIT) begin
              rdv_d = 1'b1;
              rdd_d = rx_next;
            end
          end
        end
      end
      ST_HIGH: begin
        if (tick) begin
          sclk_d  = 1'b0;
          bit_d   = bit_q + 1'b1;
          state_d = ST_LOW;
          if (bit_q != LAST_BIT) begin
            tx_d = tx_q >> 1;
          end else if (cmd_ph_q || (left_q != ONE_BYTE)) begin
            if (!cmd_ph_q) left_d = left_q - 1'b1;
            cmd_ph_d = 1'b0;
            if (!rnw_q) begin
              if (buf_full) begin
                tx_d = buf_data;
                take = 1'b1;
              end else begin
                wait_d = 1'b1;
              end
            end
          end else begin
            state_d = ST_TAIL;
            oe_d    = 1'b0;
          end
        end
      end
      ST_TAIL: begin
        if (tick) begin
          state_d = ST_GAP;
          ce_d    = 1'b0;
          gap_d   = 1'b0;
        end
      end
      ST_GAP: begin
        if (tick) begin
          if (gap_q) state_d = ST_IDLE;
          gap_d = ~gap_q;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (abort_hit) begin
      state_d = ST_GAP;
      ce_d    = 1'b0;
      sclk_d  = 1'b0;
      oe_d    = 1'b0;
      gap_d   = 1'b0;
      wait_d  = 1'b0;
      rdv_d   = 1'b0;
      take    = 1'b0;
      flush   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q  <= ST_IDLE;
      ce_q     <= 1'b0;
      sclk_q   <= 1'b0;
      oe_q     <= 1'b0;
      tx_q     <= '0;
      rx_q     <= '0;
      rdd_q    <= '0;
      bit_q    <= '0;
      cmd_ph_q <= 1'b0;
      rnw_q    <= 1'b0;
      wait_q   <= 1'b0;
      gap_q    <= 1'b0;
      left_q   <= '0;
      rdv_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      ce_q     <= ce_d;
      sclk_q   <= sclk_d;
      oe_q     <= oe_d;
      tx_q     <= tx_d;
      rx_q     <= rx_d;
      rdd_q    <= rdd_d;
      bit_q    <= bit_d;
      cmd_ph_q <= cmd_ph_d;
      rnw_q    <= rnw_d;
      wait_q   <= wait_d;
      gap_q    <= gap_d;
      left_q   <= left_d;
      rdv_q    <= rdv_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign ce        = ce_q;
  assign sclk      = sclk_q;
  assign sio_o     = tx_q[0];
  assign sio_oe    = oe_q;
  assign rd_valid  = rdv_q;
  assign rd_data   = rdd_q;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_IDLE) |-> (!ce_q && !sclk_q && !oe_q));
  // R2
  ce_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(ce_q) |-> !sclk_q);
  // R2
  clk_framed_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    sclk_q |-> ce_q);
  // R6
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (sclk_q && rnw_q && !cmd_ph_q) |-> !oe_q);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    wait_q |-> (!sclk_q && ce_q));
  // R10
  abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    abort_hit |=> (!ce_q && !oe_q && (state_q == ST_GAP)));
  // R7
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    rdv_q |=> !rdv_q);
endmodule

// File: tb/rtc3w_master_test.sv
module rtc3w_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 8;
  localparam int CNT_W = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic [DIV_W-1:0] half_div;
  logic req_valid, req_ready;
  logic [7:0] req_cmd;
  logic [CNT_W-1:0] req_len;
  logic wr_valid, wr_ready;
  logic [7:0] wr_data;
  logic rd_valid;
  logic [7:0] rd_data;
  logic abort, busy, ce, sclk, sio_o, sio_oe, sio_i;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc3w_master #(.DIV_W(DIV_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .half_div(half_div),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .abort(abort), .busy(busy),
    .ce(ce), .sclk(sclk), .sio_o(sio_o), .sio_oe(sio_oe), .sio_i(sio_i)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dev_byte(input logic [7:0] cmd, input int j);
    return cmd ^ (8'h5A + 8'(j * 29));
  endfunction

  // peripheral model
  logic       dev_bit = 1'b0;
  int         pcount = 0;
  logic [7:0] mcmd = 8'h00;
  logic [7:0] wbytes [0:15];
  int         oe_viol = 0;

  assign sio_i = sio_oe ? sio_o : dev_bit;

  always @(posedge ce) begin
    pcount = 0;
    mcmd   = 8'h00;
  end

  always @(posedge sclk) if (ce) begin
    if (pcount < 8) mcmd[pcount] = sio_o;
    else if (!mcmd[0] && (pcount - 8) < 128) wbytes[(pcount-8) >> 3][(pcount-8) & 7] = sio_o;
    if (mcmd[0] && pcount >= 8 && sio_oe) oe_viol++;
    pcount++;
  end

  always @(negedge sclk) if (ce && mcmd[0] && pcount >= 8) begin
    automatic logic [7:0] b = dev_byte(mcmd, (pcount - 8) >> 3);
    dev_bit = b[(pcount - 8) & 7];
  end

  // read collector
  int         rd_cnt = 0;
  logic [7:0] rbytes [0:255];
  always @(negedge clk) if (rd_valid) begin
    rbytes[rd_cnt & 255] = rd_data;
    rd_cnt++;
  end

  // timing monitor for R2, R3, R11
  bit mon_on = 1'b0;
  int cur_hd = 1;
  int gap_hd = 1;
  int run_len = 1000;
  logic p_ce = 1'b0, p_sclk = 1'b0;
  always @(negedge clk) if (mon_on) begin
    if (ce !== p_ce) begin
      if (ce) begin
        chk(sclk == 1'b0, "R2 ce rise with sclk low", sclk, 0);
        chk(run_len >= 2*(gap_hd+1), "R11 gap length", run_len, 2*(gap_hd+1));
      end else gap_hd = cur_hd;
      run_len = 1;
    end else if (sclk !== p_sclk && ce) begin
      if (!sclk) chk(run_len == cur_hd+1, "R3 high phase", run_len, cur_hd+1);
      else       chk(run_len >= cur_hd+1, "R3 low phase", run_len, cur_hd+1);
      run_len = 1;
    end else begin
      if (sclk) chk(ce == 1'b1, "R2 sclk only inside frame", ce, 1);
      run_len++;
    end
    p_ce = ce;
    p_sclk = sclk;
  end

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    finish_up();
  end

  task automatic idle_check(input string tag);
    chk(!ce && !sclk && !sio_oe && !busy && req_ready, tag,
        {ce, sclk, sio_oe, busy, req_ready}, 5'b00001);
  endtask

  task automatic run_txn(input logic [7:0] cmd, input int len, input int maxd, input bit stall);
    int eff;
    int base;
    int ovb;
    logic [7:0] sent [0:15];
    eff = (len == 0) ? 1 : len;
    while (!req_ready) @(negedge clk);
    base = rd_cnt;
    ovb  = oe_viol;
    for (int i = 0; i < eff; i++) sent[i] = 8'($urandom);
    req_valid = 1'b1; req_cmd = cmd; req_len = CNT_W'(len);
    @(negedge clk);
    req_valid = 1'b0;
    if (!cmd[0]) begin
      for (int i = 0; i < eff; i++) begin
        if (maxd > 0) repeat ($urandom % (maxd + 1)) @(negedge clk);
        if (stall && i == 1) begin
          repeat (150) @(negedge clk);
          // R9: starved write holds clock low inside the frame
          chk(!sclk && ce && busy, "R9 stall holds sclk low", {sclk, ce, busy}, 3'b011);
        end
        wr_valid = 1'b1; wr_data = sent[i];
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
      end
    end
    while (busy) @(negedge clk);
    idle_check("R1 idle after frame");
    chk(mcmd == cmd, "R4 command byte", mcmd, cmd);
    chk(pcount == 8 + 8*eff, "R8 rising edge count", pcount, 8 + 8*eff);
    if (!cmd[0]) begin
      for (int i = 0; i < eff; i++)
        chk(wbytes[i] == sent[i], "R5 write byte", wbytes[i], sent[i]);
    end else begin
      chk(rd_cnt - base == eff, "R7 read byte count", rd_cnt - base, eff);
      for (int i = 0; i < eff; i++)
        chk(rbytes[(base+i) & 255] == dev_byte(cmd, i), "R7 read byte",
            rbytes[(base+i) & 255], dev_byte(cmd, i));
      chk(oe_viol == ovb, "R6 data line released", oe_viol - ovb, 0);
    end
  endtask

  initial begin
    int nb;
    rst_n = 1'b0; half_div = 8'd1; cur_hd = 1;
    req_valid = 1'b0; req_cmd = '0; req_len = '0;
    wr_valid = 1'b0; wr_data = '0; abort = 1'b0;
    void'($urandom(32'd11));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;
    idle_check("R1 reset state");
    chk(rd_valid == 1'b0, "R1 no strobe at reset", rd_valid, 0);

    // directed cases
    run_txn(8'h8E, 1, 0, 1'b0);      // R5 single write
    run_txn(8'h81, 1, 0, 1'b0);      // R7 single read
    run_txn(8'hBF, 7, 0, 1'b0);      // R7 burst read
    run_txn(8'hBE, 0, 0, 1'b0);      // R8 zero count taken as one
    run_txn(8'hC0, 3, 2, 1'b1);      // R9 starved burst write
    half_div = 8'd0; cur_hd = 0;
    run_txn(8'hC1, 4, 0, 1'b0);      // R3 single-cycle phases, read
    run_txn(8'hC2, 3, 1, 1'b0);      // R3 single-cycle phases, write

    // R10 abort in mid read burst
    half_div = 8'd1; cur_hd = 1;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_cmd = 8'hC3; req_len = CNT_W'(4);
    nb = rd_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    while (rd_cnt < nb + 1) @(negedge clk);
    repeat (3) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(!ce && !sio_oe, "R10 abort drops ce and oe", {ce, sio_oe}, 2'b00);
    nb = rd_cnt;
    while (busy) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(rd_cnt == nb, "R10 no strobe after abort", rd_cnt, nb);
    idle_check("R1 idle after abort");
    run_txn(8'h85, 2, 0, 1'b0);

    // constrained random frames
    for (int t = 0; t < 25; t++) begin
      logic [7:0] c;
      c = 8'($urandom) | 8'h80;
      half_div = DIV_W'($urandom % 4);
      cur_hd = int'(half_div);
      run_txn(c, 1 + ($urandom % 4), 3, 1'b0);
    end

    repeat (10) @(negedge clk);
    finish_up();
  end
endmodule